// File: doc/BRIEF.md
# Serial Port with Internal Loopback and Hardware Flow Control

This block is an asynchronous serial transmitter and receiver that one small control register drives. The register turns the port on, selects internal loopback, sets a character size of five to eight data bits, holds a two-bit mode code and holds a manual request-to-send control. A byte written to the transmit holding register goes out on the serial output pin once the far end grants clear-to-send. Characters received on the serial input pin land in a receive holding register, together with a framing-error flag.

In loopback, the serial output feeds the receiver directly and the serial output pin keeps toggling. The request-to-send pin is held deasserted. The clear-to-send status then follows the manual request-to-send control instead of the pin, so software can pace the transmitter itself and test a full character round trip without external wiring. Only plain asynchronous framing is implemented. The other mode codes are stored and read back, and they change no behaviour.

Top module: `lbuart_top`

## Requirements
- R1: A control write with bit 0 set stores the fields: bit 0 enable, bit 1 loopback, bits 3:2 word length, bits 5:4 mode, bit 6 manual request-to-send. The read port returns the stored value in bits 6:0 and the clear-to-send status in bit 7.
- R2: A control write with bit 0 clear zeroes the whole control register. Within two clocks, the serial output is high, the transmit holding register reads empty and no received character is pending. While the port is disabled, writes to the transmit holding register are ignored.
- R3: A transmitted frame has one low start bit, then the data bits least significant bit first, then one high stop bit. Each bit lasts OVERSAMPLE*CLKS_PER_TICK clocks, and the line idles high.
- R4: Word-length codes 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits per character. The same setting applies to transmit and to receive.
- R5: The receiver confirms the start bit at mid-bit, samples each data bit at mid-bit and raises rxValid with the character. Bits above the selected character size read as zero. A pulse on rxRdEn clears rxValid.
- R6: A stop bit sampled low sets rxFrameErr with that character. A character with a high stop bit clears it.
- R7: Outside loopback, the clear-to-send status is the inverted ctsN pin after a two-flop synchronizer. rtsN is the inverse of the manual request-to-send bit. While the status is low, a pending byte does not start.
- R8: A clear-to-send drop in the middle of a character does not shorten that character. Only the next character waits.
- R9: In loopback, the receiver takes the internal serial output and ignores rxPin, while txPin still carries the frame.
- R10: In loopback, rtsN stays high and the clear-to-send status equals the manual request-to-send bit. Setting that bit lets the transmitter start, and clearing it holds a pending byte.
- R11: Mode codes 1 and 2 are stored and read back, and transmit and receive behave exactly as with mode 0.
- R12: A write to the transmit holding register while it is full is ignored. The byte already held is the one that is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register contents, with clear-to-send status in bit 7 |
| txWrEn | input | 1 | Transmit holding register write strobe |
| txData | input | 8 | Byte to transmit |
| txReady | output | 1 | Transmit holding register empty |
| rxRdEn | input | 1 | Acknowledge of the received character |
| rxData | output | 8 | Received character, zero-extended |
| rxValid | output | 1 | A received character is pending |
| rxFrameErr | output | 1 | Last character had a low stop bit |
| rxPin | input | 1 | Serial input pin |
| txPin | output | 1 | Serial output pin |
| ctsN | input | 1 | Clear-to-send pin, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| ctsStatus | output | 1 | Clear-to-send status |

## Verification
The hardest case to reach from the ports is a clear-to-send drop that lands in the middle of a character while a second byte is already waiting in the holding register. The bench forks a frame capture alongside a thread that raises ctsN four bit periods into the frame and loads the next byte. It then checks three things: the first character arrives whole, the line stays idle for several bit times, and the waiting byte leaves only once ctsN is low again. Loopback gating is reached by leaving rxPin held low, so any leak from the pin corrupts the received byte, and then clearing the manual request-to-send bit while a byte is pending.

// File: rtl/lbuart_pkg.sv
package lbuart_pkg;

  typedef struct packed {
    logic       manualRts;
    logic [1:0] mode;
    logic [1:0] wordLen;
    logic       loopEn;
    logic       enable;
  } ctlReg_t;

  typedef struct packed {
    logic       clear;
    logic       txLoad;
    logic       txGo;
    logic       rxAck;
    logic       rxLine;
    logic [1:0] wordLen;
  } strobes_t;

endpackage

// File: rtl/lbuart_ctrl.sv
module lbuart_ctrl
  import lbuart_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       txWrEn,
  input  logic       rxRdEn,
  input  logic       rxPin,
  input  logic       ctsN,
  input  logic       txLine,
  input  logic       txIdle,
  input  logic       holdFull,
  output ctlReg_t    ctl,
  output logic       ctsStatus,
  output logic       rtsN,
  output strobes_t   stb
);

  logic [1:0] ctsSync;
  logic [1:0] rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl <= '0;
    end else if (regWrEn) begin
      if (regWrData[0]) ctl <= ctlReg_t'(regWrData[6:0]);
      else              ctl <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsSync <= '0;
      rxSync  <= 2'b11;
    end else begin
      ctsSync <= {ctsSync[0], ~ctsN};
      rxSync  <= {rxSync[0], rxPin};
    end
  end

  always_comb begin
    ctsStatus   = ctl.loopEn ? ctl.manualRts : ctsSync[1];
    rtsN        = ~(ctl.manualRts & ~ctl.loopEn);
    stb.clear   = ~ctl.enable;
    stb.txLoad  = txWrEn & ctl.enable;
    stb.txGo    = ctl.enable & holdFull & txIdle & ctsStatus;
    stb.rxAck   = rxRdEn;
    stb.rxLine  = ctl.loopEn ? txLine : rxSync[1];
    stb.wordLen = ctl.wordLen;
  end

endmodule

// File: rtl/lbuart_datapath.sv
module lbuart_datapath
  import lbuart_pkg::*;
#(
  parameter int CLKS_PER_TICK = 8,
  parameter int OVERSAMPLE    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   stb,
  input  logic [7:0] txData,
  output logic       txLine,
  output logic       txIdle,
  output logic       holdFull,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       rxFrameErr
);

  localparam int BIT_CLKS = CLKS_PER_TICK * OVERSAMPLE;
  localparam int CW       = $clog2(BIT_CLKS);
  localparam int TW       = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int PW       = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CLKS - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(CLKS_PER_TICK - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(OVERSAMPLE - 1);
  localparam logic [PW-1:0] PH_HALF   = PW'(OVERSAMPLE / 2 - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} lineState_t;

  logic [2:0] lastIdx;
  assign lastIdx = {1'b0, stb.wordLen} + 3'd4;

  // transmit side
  lineState_t txState;
  logic [CW-1:0] txCnt;
  logic [2:0]    txIdx;
  logic [7:0]    txShift;
  logic [7:0]    holdData;

  assign txIdle = (txState == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState  <= S_IDLE;
      txCnt    <= '0;
      txIdx    <= '0;
      txShift  <= '0;
      txLine   <= 1'b1;
      holdData <= '0;
      holdFull <= 1'b0;
    end else if (stb.clear) begin
      txState  <= S_IDLE;
      txCnt    <= '0;
      txIdx    <= '0;
      txLine   <= 1'b1;
      holdFull <= 1'b0;
    end else begin
      if (stb.txLoad && !holdFull) begin
        holdData <= txData;
        holdFull <= 1'b1;
      end
      case (txState)
        S_IDLE: if (stb.txGo) begin
          txShift  <= holdData;
          holdFull <= 1'b0;
          txState  <= S_START;
          txCnt    <= '0;
          txLine   <= 1'b0;
        end
        S_START: begin
          txCnt <= txCnt + 1'b1;
          if (txCnt == BIT_LAST) begin
            txCnt   <= '0;
            txState <= S_DATA;
            txIdx   <= '0;
            txLine  <= txShift[0];
          end
        end
        S_DATA: begin
          txCnt <= txCnt + 1'b1;
          if (txCnt == BIT_LAST) begin
            txCnt <= '0;
            if (txIdx == lastIdx) begin
              txState <= S_STOP;
              txLine  <= 1'b1;
            end else begin
              txIdx   <= txIdx + 1'b1;
              txShift <= txShift >> 1;
              txLine  <= txShift[1];
            end
          end
        end
        default: begin
          txCnt <= txCnt + 1'b1;
          if (txCnt == BIT_LAST) begin
            txCnt   <= '0;
            txState <= S_IDLE;
          end
        end
      endcase
    end
  end

  // receive side
  lineState_t rxState;
  logic [TW-1:0] tickCnt;
  logic [PW-1:0] phase;
  logic [2:0]    rxIdx;
  logic [7:0]    rxShift;
  logic          tick;

  assign tick = (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState    <= S_IDLE;
      tickCnt    <= '0;
      phase      <= '0;
      rxIdx      <= '0;
      rxShift    <= '0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
    end else if (stb.clear) begin
      rxState    <= S_IDLE;
      tickCnt    <= '0;
      phase      <= '0;
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      if (stb.rxAck) rxValid <= 1'b0;
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      if (tick) phase <= phase + 1'b1;
      case (rxState)
        S_IDLE: if (!stb.rxLine) begin
          rxState <= S_START;
          tickCnt <= '0;
          phase   <= '0;
        end
        S_START: if (tick && phase == PH_HALF) begin
          phase <= '0;
          if (!stb.rxLine) begin
            rxState <= S_DATA;
            rxIdx   <= '0;
            rxShift <= '0;
          end else begin
            rxState <= S_IDLE;
          end
        end
        S_DATA: if (tick && phase == PH_LAST) begin
          rxShift[rxIdx] <= stb.rxLine;
          if (rxIdx == lastIdx) rxState <= S_STOP;
          else                  rxIdx   <= rxIdx + 1'b1;
        end
        default: if (tick && phase == PH_LAST) begin
          rxData     <= rxShift;
          rxFrameErr <= ~stb.rxLine;
          rxValid    <= 1'b1;
          rxState    <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/lbuart_top.sv
module lbuart_top
  import lbuart_pkg::*;
#(
  parameter int CLKS_PER_TICK = 8,
  parameter int OVERSAMPLE    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       txWrEn,
  input  logic [7:0] txData,
  output logic       txReady,
  input  logic       rxRdEn,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       rxFrameErr,
  input  logic       rxPin,
  output logic       txPin,
  input  logic       ctsN,
  output logic       rtsN,
  output logic       ctsStatus
);

  ctlReg_t  ctl;
  strobes_t stb;
  logic     txLine;
  logic     txIdle;
  logic     holdFull;

  lbuart_ctrl i_ctrl (
    .clk, .rstN, .regWrEn, .regWrData, .txWrEn, .rxRdEn, .rxPin, .ctsN,
    .txLine, .txIdle, .holdFull, .ctl, .ctsStatus, .rtsN, .stb
  );

  lbuart_datapath #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .OVERSAMPLE   (OVERSAMPLE)
  ) i_dp (
    .clk, .rstN, .stb, .txData, .txLine, .txIdle, .holdFull,
    .rxData, .rxValid, .rxFrameErr
  );

  assign regRdData = {ctsStatus, ctl};
  assign txReady   = ~holdFull;
  assign txPin     = txLine;

endmodule

// File: rtl/lbuart_checker.sv
module lbuart_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       txReady,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       txPin,
  input logic       rtsN,
  input logic       ctsStatus
);

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!regRdData[0]) && !regRdData[0]) |-> (txPin && txReady && !rxValid));

  a_r5_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxValid) && regRdData[3:2] == 2'd0) |-> (rxData[7:5] == 3'b000));

  a_r7_rts_follows_manual: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[0] && !regRdData[1]) |-> (rtsN == !regRdData[6]));

  a_r10_loop_rts_high: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[1] |-> rtsN);

  a_r10_loop_cts_tied: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[1] |-> (ctsStatus == regRdData[6]));

endmodule

bind lbuart_top lbuart_checker i_chk (
  .clk, .rstN, .regRdData, .txReady, .rxData, .rxValid, .txPin, .rtsN, .ctsStatus
);

// File: tb/test_lbuart_top.sv
module test_lbuart_top;

  localparam int CPT = 2;
  localparam int OS  = 16;
  localparam int BIT = CPT * OS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       txWrEn = 1'b0;
  logic [7:0] txData = '0;
  logic       txReady;
  logic       rxRdEn = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxFrameErr;
  logic       rxPin = 1'b1;
  logic       txPin;
  logic       ctsN = 1'b0;
  logic       rtsN;
  logic       ctsStatus;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lbuart_top #(.CLKS_PER_TICK(CPT), .OVERSAMPLE(OS)) i_lbuart_top (
    .clk, .rstN, .regWrEn, .regWrData, .regRdData, .txWrEn, .txData, .txReady,
    .rxRdEn, .rxData, .rxValid, .rxFrameErr, .rxPin, .txPin, .ctsN, .rtsN, .ctsStatus
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeCtl(input bit en, input bit lp, input logic [1:0] wl,
                          input logic [1:0] md, input bit rts);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = {1'b0, rts, md, wl, lp, en};
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic writeTx(input logic [7:0] d);
    @(negedge clk);
    txWrEn = 1'b1;
    txData = d;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic ackRx();
    @(negedge clk);
    rxRdEn = 1'b1;
    @(negedge clk);
    rxRdEn = 1'b0;
  endtask

  task automatic captureTx(input int nb, output logic [7:0] d, output logic stopBit,
                           output logic startOk);
    int t = 0;
    d = '0; stopBit = 1'b0; startOk = 1'b0;
    while (txPin !== 1'b0 && t < 40 * BIT) begin @(negedge clk); t++; end
    if (txPin !== 1'b0) return;
    repeat (BIT / 2) @(negedge clk);
    startOk = (txPin === 1'b0);
    for (int i = 0; i < nb; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = txPin;
    end
    repeat (BIT) @(negedge clk);
    stopBit = txPin;
  endtask

  task automatic sendRx(input int nb, input logic [7:0] d, input logic stopVal);
    @(negedge clk);
    rxPin = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxPin = d[i];
      repeat (BIT) @(negedge clk);
    end
    rxPin = stopVal;
    repeat (BIT) @(negedge clk);
    rxPin = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic waitRx(output bit got);
    got = 0;
    for (int t = 0; t < 40 * BIT; t++) begin
      if (rxValid === 1'b1) begin got = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic idleFor(input int n, output int lows);
    lows = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (txPin !== 1'b1) lows++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(regRdData == 8'h00, "R2 reset ctl", regRdData, 0);
    check(txPin === 1'b1 && rtsN === 1'b1, "R2 reset pins", {txPin, rtsN}, 2'b11);
    check(txReady === 1'b1 && rxValid === 1'b0, "R2 reset flags", {txReady, rxValid}, 2'b10);
  endtask

  task automatic t_regs();
    writeCtl(1, 0, 2'd3, 2'd2, 1);
    @(negedge clk);
    check(regRdData[6:0] == 7'b1101101, "R1 readback", regRdData[6:0], 7'b1101101);
    check(regRdData[7] == 1'b1, "R1 cts status bit", regRdData[7], 1);
    check(rtsN === 1'b0, "R7 rts asserted by manual bit", rtsN, 0);
    writeCtl(1, 0, 2'd3, 2'd0, 0);
    @(negedge clk);
    check(rtsN === 1'b1, "R7 rts released", rtsN, 1);
    regWrData = 8'h7E;
    @(negedge clk); regWrEn = 1'b1; @(negedge clk); regWrEn = 1'b0;
    @(negedge clk);
    check(regRdData[6:0] == 7'h00, "R2 disable write clears ctl", regRdData, 0);
    writeTx(8'h33);
    check(txReady === 1'b1, "R2 tx write ignored while disabled", txReady, 1);
  endtask

  task automatic t_frames();
    logic [7:0] d; logic sb, so; bit got;
    logic [7:0] vals [4] = '{8'hA5, 8'h96, 8'hD3, 8'h6B};
    for (int wl = 3; wl >= 0; wl--) begin
      int nb = wl + 5;
      logic [7:0] mask = 8'hFF >> (8 - nb);
      writeCtl(1, 0, wl[1:0], 2'd0, 0);
      writeTx(vals[wl]);
      captureTx(nb, d, sb, so);
      check(so && sb, "R3 start low stop high", {so, sb}, 2'b11);
      check(d == (vals[wl] & mask), "R4 tx data bits", d, vals[wl] & mask);
      repeat (BIT) @(negedge clk);
      sendRx(nb, vals[wl] ^ 8'hFF, 1'b1);
      waitRx(got);
      check(got && rxData == ((vals[wl] ^ 8'hFF) & mask), "R5 rx data zero-extended",
            rxData, (vals[wl] ^ 8'hFF) & mask);
      check(rxFrameErr === 1'b0, "R6 good stop", rxFrameErr, 0);
      ackRx();
      check(rxValid === 1'b0, "R5 ack clears valid", rxValid, 0);
    end
  endtask

  task automatic t_frameErr();
    bit got;
    writeCtl(1, 0, 2'd3, 2'd0, 0);
    sendRx(8, 8'h4C, 1'b0);
    waitRx(got);
    check(got && rxFrameErr === 1'b1, "R6 low stop sets error", rxFrameErr, 1);
    ackRx();
    sendRx(8, 8'h21, 1'b1);
    waitRx(got);
    check(got && rxFrameErr === 1'b0 && rxData == 8'h21, "R6 error cleared", {rxFrameErr, rxData}, 9'h021);
    ackRx();
  endtask

  task automatic t_flow();
    logic [7:0] d; logic sb, so; int lows;
    writeCtl(1, 0, 2'd3, 2'd0, 0);
    ctsN = 1'b1;
    repeat (4) @(negedge clk);
    check(ctsStatus === 1'b0, "R7 status follows pin", ctsStatus, 0);
    writeTx(8'h81);
    writeTx(8'h7E);
    idleFor(4 * BIT, lows);
    check(lows == 0 && txReady === 1'b0, "R7 held while cts deasserted", lows, 0);
    ctsN = 1'b0;
    captureTx(8, d, sb, so);
    check(d == 8'h81 && sb && so, "R12 held byte sent, second write ignored", d, 8'h81);
    idleFor(3 * BIT, lows);
    check(lows == 0 && txReady === 1'b1, "R12 no extra frame", lows, 0);
  endtask

  task automatic t_ctsMid();
    logic [7:0] d; logic sb, so; int lows;
    writeCtl(1, 0, 2'd3, 2'd0, 0);
    writeTx(8'h5A);
    fork
      captureTx(8, d, sb, so);
      begin
        repeat (4 * BIT) @(negedge clk);
        ctsN = 1'b1;
        txWrEn = 1'b1; txData = 8'hC3;
        @(negedge clk);
        txWrEn = 1'b0;
      end
    join
    check(d == 8'h5A && sb && so, "R8 character completes after cts drop", d, 8'h5A);
    idleFor(4 * BIT, lows);
    check(lows == 0, "R8 next character waits", lows, 0);
    ctsN = 1'b0;
    captureTx(8, d, sb, so);
    check(d == 8'hC3 && sb, "R8 next character after cts return", d, 8'hC3);
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_loop();
    logic [7:0] d; logic sb, so; bit got; int lows;
    ctsN = 1'b1;
    rxPin = 1'b0;
    writeCtl(1, 1, 2'd3, 2'd0, 1);
    @(negedge clk);
    check(rtsN === 1'b1 && ctsStatus === 1'b1, "R10 rts high, cts from manual bit", {rtsN, ctsStatus}, 2'b11);
    writeTx(8'h3C);
    captureTx(8, d, sb, so);
    check(d == 8'h3C && sb && so, "R9 tx pin still driven", d, 8'h3C);
    waitRx(got);
    check(got && rxData == 8'h3C && !rxFrameErr, "R9 receiver sees tx, not pin", rxData, 8'h3C);
    ackRx();
    repeat (BIT) @(negedge clk);
    writeCtl(1, 1, 2'd3, 2'd0, 0);
    @(negedge clk);
    check(ctsStatus === 1'b0 && rtsN === 1'b1, "R10 manual clear drops status", {rtsN, ctsStatus}, 2'b10);
    writeTx(8'hE7);
    idleFor(4 * BIT, lows);
    check(lows == 0 && txReady === 1'b0, "R10 transmitter stalled", lows, 0);
    writeCtl(1, 1, 2'd3, 2'd0, 1);
    captureTx(8, d, sb, so);
    check(d == 8'hE7, "R10 transmitter resumes", d, 8'hE7);
    waitRx(got);
    check(got && rxData == 8'hE7, "R9 loop receive second byte", rxData, 8'hE7);
    ackRx();
    rxPin = 1'b1;
    ctsN = 1'b0;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_modes();
    logic [7:0] d; logic sb, so; bit got;
    for (int m = 1; m <= 2; m++) begin
      writeCtl(1, 0, 2'd2, m[1:0], 0);
      @(negedge clk);
      check(regRdData[5:4] == m[1:0], "R11 mode stored", regRdData[5:4], m);
      writeTx(8'h55);
      captureTx(7, d, sb, so);
      check(d == 8'h55 && sb && so, "R11 tx unaffected by mode", d, 8'h55);
      repeat (BIT) @(negedge clk);
      sendRx(7, 8'h2A, 1'b1);
      waitRx(got);
      check(got && rxData == 8'h2A, "R11 rx unaffected by mode", rxData, 8'h2A);
      ackRx();
    end
  endtask

  task automatic t_disable();
    bit got; logic dummy;
    writeCtl(1, 0, 2'd3, 2'd0, 0);
    sendRx(8, 8'h99, 1'b1);
    waitRx(got);
    check(got, "R5 char pending before disable", got, 1);
    writeTx(8'h00);
    repeat (3 * BIT) @(negedge clk);
    dummy = txPin;
    check(dummy === 1'b0, "R3 mid-frame line low for zero byte", dummy, 0);
    writeCtl(0, 0, 2'd0, 2'd0, 0);
    @(negedge clk);
    check(txPin === 1'b1 && txReady === 1'b1 && rxValid === 1'b0, "R2 disable stops activity",
          {txPin, txReady, rxValid}, 3'b110);
    check(regRdData[6:0] == 7'h0, "R2 ctl cleared", regRdData, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_frames();
    t_frameErr();
    t_flow();
    t_ctsMid();
    t_loop();
    t_modes();
    t_disable();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule